// File: doc/BRIEF.md
# Multiply-Accumulate Product Conditioning Stage

This stage sits between a 32x32 multiplier and a 48-bit accumulate adder. Each cycle it can accept two 32-bit operands with a mode selection. One clock later it presents a 64-bit product that the adder can take without further adjustment. There are three modes. Signed integer products are checked against a 40-bit signed range. Unsigned integer products are checked against a 40-bit unsigned range. Fractional products are scaled down by 2^24 and can optionally be rounded.

When an integer product falls outside its range, a sticky overflow flag is raised. With the overflow-mode control bit clear, the product is cut down to its low 40 bits. With the bit set, it is replaced by a sentinel near ±2^50, so that the accumulate that follows overflows as well. The flag stays set until the clear input is pulsed or the block is reset.

Top module: `mac_prod_stage`

## Requirements
- R1: `out_valid` is low after reset and is high in exactly the cycle after each cycle in which `in_valid` is high.
- R2: Mode encoding is 2'b00 signed, 2'b01 unsigned, 2'b10 and 2'b11 fractional. In signed mode, when the two's-complement product fits in 40 signed bits, the output is that product sign-extended to 64 bits.
- R3: In signed mode, a product outside [-2^39, 2^39-1] counts as overflow and sets `v_flag`.
- R4: On signed overflow with `sat_en` high, the output is 2^50 (0x0004_0000_0000_0000) for a positive product and the bitwise inverse of 2^50 (0xFFFB_FFFF_FFFF_FFFF) for a negative one.
- R5: On signed overflow with `sat_en` low, the output is the product's low 40 bits, sign-extended from bit 39.
- R6: In unsigned mode the operands are unsigned. When the product is below 2^40, the output is the product unchanged and `v_flag` is not set. Any set bit in positions 40 to 63 counts as overflow and sets `v_flag`.
- R7: On unsigned overflow the output is 2^50 when `sat_en` is high, and the low 40 bits zero-extended when it is low.
- R8: In fractional mode the unsigned 64-bit product is shifted right by 24 bits. With `round_en` low the dropped bits are discarded. Fractional mode never sets `v_flag`.
- R9: In fractional mode with `round_en` high, the 24-bit remainder rounds to nearest with ties to even. A remainder above 0x800000 adds one. A remainder equal to 0x800000 adds one only when the shifted value is odd.
- R10: `v_flag` is sticky and is cleared only by reset or by `v_clear`. An overflow accepted in the same cycle as `v_clear` leaves the flag set.
- R11: `product` keeps its value in cycles where no operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are accepted this cycle |
| op_a | input | 32 | First multiplier operand |
| op_b | input | 32 | Second multiplier operand |
| mode | input | 2 | 00 signed, 01 unsigned, 1x fractional |
| sat_en | input | 1 | Replace an overflowing product with a sentinel |
| round_en | input | 1 | Round fractional products to nearest even |
| v_clear | input | 1 | Clear the sticky overflow flag |
| out_valid | output | 1 | `product` was updated at the last edge |
| product | output | 64 | Conditioned product |
| v_flag | output | 1 | Sticky overflow flag |

## Verification
Signed operands are chosen on both sides of the 40-bit limit, including -2^39, which fits, and +2^39, which overflows. This separates the range check from an off-by-one error. Large positive and large negative overflows are run with saturation both on and off, so the two sentinels and the sign-extended truncation can each be told apart. Unsigned operands bracket 2^40 to distinguish exact pass-through, zero-extended truncation and the sentinel. Fractional products are placed with remainders below, exactly at and above the half point, on both odd and even quotients, so round-half-even is distinguished from plain rounding and from truncation.

// File: rtl/mac_prod_stage.sv
module mac_prod_stage #(
  parameter int OP_W   = 32,
  parameter int RANGE_W = 40,
  parameter int SHIFT  = 24,
  parameter int SENT_BIT = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  input  logic [1:0]          mode,
  input  logic                sat_en,
  input  logic                round_en,
  input  logic                v_clear,
  output logic                out_valid,
  output logic [2*OP_W-1:0]   product,
  output logic                v_flag
);
  localparam int PW = 2 * OP_W;
  localparam int QW = PW - SHIFT;
  localparam logic [PW-1:0] SENT = PW'(1) << SENT_BIT;
  localparam logic [SHIFT-1:0] HALF = SHIFT'(1) << (SHIFT - 1);

  logic signed [PW-1:0] s_prod;
  logic [PW-1:0]        u_prod;
  logic                 s_ovf, u_ovf;
  logic [QW-1:0]        quo;
  logic [SHIFT-1:0]     rem;
  logic                 bump;
  logic [PW-1:0]        nxt;
  logic                 ovf;

  assign s_prod = $signed({{OP_W{op_a[OP_W-1]}}, op_a}) * $signed({{OP_W{op_b[OP_W-1]}}, op_b});
  assign u_prod = {{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b};

  assign s_ovf = !((&s_prod[PW-1:RANGE_W-1]) || !(|s_prod[PW-1:RANGE_W-1]));
  assign u_ovf = |u_prod[PW-1:RANGE_W];

  assign quo  = u_prod[PW-1:SHIFT];
  assign rem  = u_prod[SHIFT-1:0];
  assign bump = round_en && ((rem > HALF) || (rem == HALF && quo[0]));

  always_comb begin
    nxt = '0;
    ovf = 1'b0;
    case (mode)
      2'b00: begin
        ovf = s_ovf;
        if (!s_ovf)      nxt = s_prod;
        else if (sat_en) nxt = s_prod[PW-1] ? ~SENT : SENT;
        else             nxt = {{(PW-RANGE_W){s_prod[RANGE_W-1]}}, s_prod[RANGE_W-1:0]};
      end
      2'b01: begin
        ovf = u_ovf;
        if (!u_ovf)      nxt = u_prod;
        else if (sat_en) nxt = SENT;
        else             nxt = {{(PW-RANGE_W){1'b0}}, u_prod[RANGE_W-1:0]};
      end
      default: nxt = {{SHIFT{1'b0}}, quo} + PW'(bump);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
      v_flag    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= nxt;
      v_flag <= (v_flag && !v_clear) || (in_valid && ovf);
    end
  end
endmodule

module mac_prod_stage_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  mode,
  input logic        sat_en,
  input logic        v_clear,
  input logic        out_valid,
  input logic [63:0] product,
  input logic        v_flag
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (v_flag && !v_clear) |=> v_flag);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (v_clear && !in_valid) |=> !v_flag);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));
  a_r8_frac_no_v: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] && !v_flag) |=> !v_flag);
  a_r7_unsigned_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> (product <= 64'h0004_0000_0000_0000));
endmodule

bind mac_prod_stage mac_prod_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .sat_en(sat_en),
  .v_clear(v_clear), .out_valid(out_valid), .product(product), .v_flag(v_flag)
);

// File: tb/sim_mac_prod_stage.sv
module sim_mac_prod_stage;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  mode = '0;
  logic        sat_en = 1'b0, round_en = 1'b0, v_clear = 1'b0;
  logic        out_valid, v_flag;
  logic [63:0] product;

  int checks = 0;
  int errors = 0;
  logic exp_v = 1'b0;

  localparam logic [63:0] POS_S = 64'h0004_0000_0000_0000;
  localparam logic [63:0] NEG_S = 64'hFFFB_FFFF_FFFF_FFFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_prod_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .mode(mode), .sat_en(sat_en), .round_en(round_en), .v_clear(v_clear),
    .out_valid(out_valid), .product(product), .v_flag(v_flag)
  );

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [31:0] a, logic [31:0] b, logic [1:0] m,
                        logic sat, logic rnd, logic [63:0] exp_p, logic exp_ovf);
    @(negedge clk);
    op_a = a; op_b = b; mode = m; sat_en = sat; round_en = rnd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_v = exp_v | exp_ovf;
    check64({req, " product"}, product, exp_p);
    check64("R1 out_valid", {63'b0, out_valid}, 64'd1);
    check64({req, " v_flag"}, {63'b0, v_flag}, {63'b0, exp_v});
  endtask

  task automatic clear_v();
    @(negedge clk);
    v_clear = 1'b1;
    @(negedge clk);
    v_clear = 1'b0;
    exp_v = 1'b0;
    check64("R10 cleared", {63'b0, v_flag}, 64'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R1 reset valid", {63'b0, out_valid}, 64'd0);
    check64("R11 reset product", product, 64'd0);
    check64("R10 reset v", {63'b0, v_flag}, 64'd0);
  endtask

  task automatic t_signed();
    run_op("R2 small", 32'd3, -32'sd5, 2'b00, 1'b1, 1'b0, -64'sd15, 1'b0);
    run_op("R2 min fit", 32'h8000_0000, 32'h0000_0100, 2'b00, 1'b1, 1'b0,
           64'hFFFF_FF80_0000_0000, 1'b0);
    run_op("R3 just over", 32'h8000_0000, 32'hFFFF_FF00, 2'b00, 1'b1, 1'b0, POS_S, 1'b1);
    clear_v();
    run_op("R4 pos sentinel", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b00, 1'b1, 1'b0, POS_S, 1'b1);
    clear_v();
    run_op("R4 neg sentinel", 32'h8000_0000, 32'h7FFF_FFFF, 2'b00, 1'b1, 1'b0, NEG_S, 1'b1);
    clear_v();
    run_op("R5 trunc pos", 32'h8000_0000, 32'hFFFF_FF00, 2'b00, 1'b0, 1'b0,
           64'hFFFF_FF80_0000_0000, 1'b1);
    clear_v();
    run_op("R5 trunc neg", 32'h8000_0000, 32'h7FFF_FFFF, 2'b00, 1'b0, 1'b0,
           64'h0000_0000_8000_0000, 1'b1);
    clear_v();
  endtask

  task automatic t_unsigned();
    run_op("R6 fits", 32'hFFFF_FFFF, 32'h0000_0100, 2'b01, 1'b1, 1'b0,
           64'h0000_00FF_FFFF_FF00, 1'b0);
    run_op("R7 sentinel", 32'h0001_0000, 32'h0100_0000, 2'b01, 1'b1, 1'b0, POS_S, 1'b1);
    clear_v();
    run_op("R7 trunc", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 1'b0, 1'b0,
           64'h0000_00FE_0000_0001, 1'b1);
    clear_v();
  endtask

  task automatic t_frac();
    run_op("R8 trunc", 32'd1, 32'h0280_0001, 2'b10, 1'b1, 1'b0, 64'd2, 1'b0);
    run_op("R8 large", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b11, 1'b1, 1'b0,
           64'h0000_00FF_FFFF_FE00, 1'b0);
    run_op("R9 tie odd", 32'd1, 32'h0180_0000, 2'b10, 1'b0, 1'b1, 64'd2, 1'b0);
    run_op("R9 tie even", 32'd1, 32'h0280_0000, 2'b10, 1'b0, 1'b1, 64'd2, 1'b0);
    run_op("R9 above half", 32'd1, 32'h0280_0001, 2'b10, 1'b0, 1'b1, 64'd3, 1'b0);
    run_op("R9 below half", 32'd1, 32'h037F_FFFF, 2'b10, 1'b0, 1'b1, 64'd3, 1'b0);
  endtask

  task automatic t_sticky_hold();
    logic [63:0] held;
    run_op("R10 set", 32'h0001_0000, 32'h0100_0000, 2'b01, 1'b1, 1'b0, POS_S, 1'b1);
    run_op("R10 sticky", 32'd2, 32'd3, 2'b00, 1'b0, 1'b0, 64'd6, 1'b0);
    @(negedge clk);
    op_a = 32'h0001_0000; op_b = 32'h0100_0000; mode = 2'b01; sat_en = 1'b1;
    in_valid = 1'b1; v_clear = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; v_clear = 1'b0;
    check64("R10 set beats clear", {63'b0, v_flag}, 64'd1);
    clear_v();
    held = product;
    op_a = 32'h1234_5678; op_b = 32'h9ABC_DEF0; mode = 2'b00;
    repeat (3) @(negedge clk);
    check64("R11 hold product", product, held);
    check64("R1 idle valid", {63'b0, out_valid}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_signed();
    t_unsigned();
    t_frac();
    t_sticky_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule